// File: doc/BRIEF.md
# Two-Bank Clock Divider with Frequency Select and Test Override

The block takes one input clock and produces two divided bank clocks, A and B, plus a reference output that carries the input clock itself. Each bank divides by one of four even ratios. The ratios are 4, 6, 8 and 12, chosen by a 2-bit code. The two codes come either from four external select pins or from fields of an 8-bit control byte. Which source is used depends on one bit of that byte. The byte is loaded whole on a clock edge while a write strobe is high.

A second bit of the byte places the block in a test mode. In that mode the pins and the register codes are both ignored. Bank A divides by 6, bank B divides by 4, and the reference output still follows the input clock. Every bank output keeps a 50% duty cycle. A new ratio is adopted only when the current output period finishes, so a select change never produces a short high or low phase.

Top module: `clkbank_ctrl`

## Requirements
- R1: While control bit 7 is 0 (test mode), `clk_a` runs at the input clock divided by 6: 3 cycles high, then 3 cycles low.
- R2: While control bit 7 is 0, `clk_b` runs at the input clock divided by 4: 2 cycles high, then 2 cycles low.
- R3: `ref_clk` equals `clk_in` at all times, in test mode and in normal mode.
- R4: Reset loads the control byte with 0x81. Bit 7 = 1 selects normal mode and bit 0 = 1 selects the pin source; all other bits are 0. Both bank clocks are low while reset is asserted.
- R5: While bit 0 is 1, the bank A code is {sa_pin[1], sa_pin[0]} and the bank B code is {sb_pin[1], sb_pin[0]}.
- R6: Code 0 divides by 4, code 1 by 6, code 2 by 8 and code 3 by 12. The high time and the low time are each half the divisor.
- R7: While bit 0 is 0, the bank A code is control bits [2:1] and the bank B code is control bits [4:3].
- R8: While bit 0 is 0, changes on `sa_pin` and `sb_pin` have no effect on either bank output.
- R9: A change of divisor is adopted only at the falling edge that ends a full output period. Every high or low phase lasts exactly half of either the old divisor or the new one, and high and low within one period are equal.
- R10: Test mode takes priority over both the pin source and the register source.
- R11: The control byte loads `ctl_wdata` on a clock edge only when `ctl_we` is 1. With `ctl_we` at 0 it holds its value whatever `ctl_wdata` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock, source of all outputs |
| rst_n | input | 1 | Asynchronous reset, active low |
| sa_pin | input | 2 | Bank A frequency select pins |
| sb_pin | input | 2 | Bank B frequency select pins |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_we | input | 1 | Control byte write strobe |
| clk_a | output | 1 | Bank A divided clock |
| clk_b | output | 1 | Bank B divided clock |
| ref_clk | output | 1 | Reference output, equal to the input clock |

## Verification
The bench changes a select in the middle of a low phase and checks the exact sequence of phase lengths that follows. A design that reloads its divisor at once, or at every toggle, would show a truncated phase or a period with unequal high and low. Register mode is driven with pin values that differ from the register codes, and a pin change is made in that mode. A design that muxes the wrong source, or swaps the two code fields, would run at the pin ratio or at the other bank's ratio. The bench holds test-mode data on the write bus with the strobe low, which would catch a register that loads without the strobe. It also enters test mode with conflicting codes from both sources, which would catch a design that lets a source override test mode.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;

   typedef logic [1:0] fsel_t;

   // Control byte layout: the bit positions are behaviour, decoded by the bank muxes
   typedef struct packed {
      logic  norm_mode;   // bit 7: 1 = normal, 0 = test override
      logic  [1:0] spare; // bits 6:5: stored, no function
      fsel_t sel_b;       // bits 4:3: bank B register code
      fsel_t sel_a;       // bits 2:1: bank A register code
      logic  pin_src;     // bit 0: 1 = codes from pins
   } ctl_t;

   localparam logic [7:0] CTL_RESET = 8'h81;

   function automatic int imax(int a, int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/clkbank_ctlreg.sv
module clkbank_ctlreg
   import clkbank_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] wdata,
   output ctl_t       ctl_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= ctl_t'(CTL_RESET);
      end else if (we) begin
         ctl_q <= ctl_t'(wdata);
      end
   end

endmodule

// File: rtl/clkbank_selmux.sv
module clkbank_selmux
   import clkbank_pkg::*;
#(
   parameter int CNT_W    = 3,
   parameter int DIV_C0   = 4,
   parameter int DIV_C1   = 6,
   parameter int DIV_C2   = 8,
   parameter int DIV_C3   = 12,
   parameter int TEST_DIV = 6
) (
   input  logic             test_mode,
   input  logic             pin_src,
   input  fsel_t            pin_sel,
   input  fsel_t            reg_sel,
   output logic [CNT_W-1:0] half_o
);

   localparam logic [CNT_W-1:0] H0 = CNT_W'(DIV_C0 / 2);
   localparam logic [CNT_W-1:0] H1 = CNT_W'(DIV_C1 / 2);
   localparam logic [CNT_W-1:0] H2 = CNT_W'(DIV_C2 / 2);
   localparam logic [CNT_W-1:0] H3 = CNT_W'(DIV_C3 / 2);
   localparam logic [CNT_W-1:0] HT = CNT_W'(TEST_DIV / 2);

   fsel_t code;

   always_comb begin
      code = pin_src ? pin_sel : reg_sel;
      unique case (code)
         2'd0:    half_o = H0;
         2'd1:    half_o = H1;
         2'd2:    half_o = H2;
         default: half_o = H3;
      endcase
      if (test_mode) begin
         half_o = HT;
      end
   end

endmodule

// File: rtl/clkbank_div.sv
module clkbank_div #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] req_half,
   output logic             clk_o
);

   logic [CNT_W-1:0] cur_half;
   logic [CNT_W-1:0] cnt;
   logic             q;

   // cur_half == 0 marks the idle state right after reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_half <= '0;
         cnt      <= '0;
         q        <= 1'b0;
      end else if (cur_half == '0) begin
         cur_half <= req_half;
         cnt      <= '0;
      end else if (cnt == cur_half - CNT_W'(1)) begin
         cnt <= '0;
         q   <= ~q;
         // a period is low then high; adopt a new ratio only as it ends
         if (q) begin
            cur_half <= req_half;
         end
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   assign clk_o = q;

endmodule

// File: rtl/clkbank_ctrl.sv
module clkbank_ctrl
   import clkbank_pkg::*;
#(
   parameter int DIV_C0     = 4,
   parameter int DIV_C1     = 6,
   parameter int DIV_C2     = 8,
   parameter int DIV_C3     = 12,
   parameter int TEST_DIV_A = 6,
   parameter int TEST_DIV_B = 4
) (
   input  logic       clk_in,
   input  logic       rst_n,
   input  logic [1:0] sa_pin,
   input  logic [1:0] sb_pin,
   input  logic [7:0] ctl_wdata,
   input  logic       ctl_we,
   output logic       clk_a,
   output logic       clk_b,
   output logic       ref_clk
);

   localparam int NBANK    = 2;
   localparam int DIVS [6] = '{DIV_C0, DIV_C1, DIV_C2, DIV_C3, TEST_DIV_A, TEST_DIV_B};
   localparam int HALF_MAX = imax(imax(imax(DIV_C0, DIV_C1), imax(DIV_C2, DIV_C3)),
                                  imax(TEST_DIV_A, TEST_DIV_B)) / 2;
   localparam int CNT_W    = $clog2(HALF_MAX + 1);

   for (genvar i = 0; i < 6; i++) begin : g_chk_div
      if ((DIVS[i] % 2) != 0 || DIVS[i] < 2) begin : g_bad
         $error("clkbank_ctrl: every divisor must be even and at least 2");
      end
   end

   ctl_t             ctl_q;
   logic [CNT_W-1:0] req_half [NBANK];
   logic [NBANK-1:0] bank_clk;

   clkbank_ctlreg u_ctl (
      .clk   (clk_in),
      .rst_n (rst_n),
      .we    (ctl_we),
      .wdata (ctl_wdata),
      .ctl_q (ctl_q)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      localparam int TDIV = (b == 0) ? TEST_DIV_A : TEST_DIV_B;

      clkbank_selmux #(
         .CNT_W    (CNT_W),
         .DIV_C0   (DIV_C0),
         .DIV_C1   (DIV_C1),
         .DIV_C2   (DIV_C2),
         .DIV_C3   (DIV_C3),
         .TEST_DIV (TDIV)
      ) u_mux (
         .test_mode (~ctl_q.norm_mode),
         .pin_src   (ctl_q.pin_src),
         .pin_sel   ((b == 0) ? sa_pin : sb_pin),
         .reg_sel   ((b == 0) ? ctl_q.sel_a : ctl_q.sel_b),
         .half_o    (req_half[b])
      );

      clkbank_div #(
         .CNT_W (CNT_W)
      ) u_div (
         .clk      (clk_in),
         .rst_n    (rst_n),
         .req_half (req_half[b]),
         .clk_o    (bank_clk[b])
      );
   end

   assign clk_a   = bank_clk[0];
   assign clk_b   = bank_clk[1];
   assign ref_clk = clk_in;

endmodule

// File: rtl/clkbank_chk.sv
module clkbank_chk #(
   parameter int CNT_W      = 3,
   parameter int DIV_C0     = 4,
   parameter int DIV_C1     = 6,
   parameter int DIV_C2     = 8,
   parameter int DIV_C3     = 12,
   parameter int TEST_DIV_A = 6,
   parameter int TEST_DIV_B = 4
) (
   input logic             clk_in,
   input logic             rst_n,
   input logic             ctl_we,
   input logic [7:0]       ctl_wdata,
   input logic [7:0]       ctl_q,
   input logic [CNT_W-1:0] req_half_a,
   input logic [CNT_W-1:0] req_half_b,
   input logic             clk_a,
   input logic             clk_b
);

   logic [1:0] bclk;
   logic [1:0] d_q;
   logic [1:0] armed;
   logic [1:0] lo_ok;
   logic [1:0] tog;
   logic [7:0] run    [2];
   logic [7:0] lo_len [2];

   assign bclk = {clk_b, clk_a};
   assign tog  = bclk ^ d_q;

   function automatic logic legal_run(logic [7:0] r);
      return (int'(r) == DIV_C0 / 2) || (int'(r) == DIV_C1 / 2) ||
             (int'(r) == DIV_C2 / 2) || (int'(r) == DIV_C3 / 2) ||
             (int'(r) == TEST_DIV_A / 2) || (int'(r) == TEST_DIV_B / 2);
   endfunction

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         d_q   <= '0;
         armed <= '0;
         lo_ok <= '0;
         for (int b = 0; b < 2; b++) begin
            run[b]    <= '0;
            lo_len[b] <= '0;
         end
      end else begin
         d_q <= bclk;
         for (int b = 0; b < 2; b++) begin
            if (tog[b]) begin
               run[b]   <= 8'd1;
               armed[b] <= 1'b1;
               if (bclk[b] && armed[b]) begin
                  lo_len[b] <= run[b];
                  lo_ok[b]  <= 1'b1;
               end
            end else if (run[b] != 8'hFF) begin
               run[b] <= run[b] + 8'd1;
            end
         end
      end
   end

   p_ctl_reset_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
      $past(!rst_n) |-> (ctl_q == 8'h81));

   p_ctl_write_r11: assert property (@(posedge clk_in) disable iff (!rst_n)
      ctl_we |=> (ctl_q == $past(ctl_wdata)));

   p_ctl_hold_r11: assert property (@(posedge clk_in) disable iff (!rst_n)
      !ctl_we |=> $stable(ctl_q));

   p_test_a_r1: assert property (@(posedge clk_in) disable iff (!rst_n)
      !ctl_q[7] |-> (int'(req_half_a) == TEST_DIV_A / 2));

   p_test_b_r2: assert property (@(posedge clk_in) disable iff (!rst_n)
      !ctl_q[7] |-> (int'(req_half_b) == TEST_DIV_B / 2));

   p_run_a_r9: assert property (@(posedge clk_in) disable iff (!rst_n)
      (armed[0] && tog[0]) |-> legal_run(run[0]));

   p_run_b_r9: assert property (@(posedge clk_in) disable iff (!rst_n)
      (armed[1] && tog[1]) |-> legal_run(run[1]));

   p_duty_a_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
      (lo_ok[0] && tog[0] && !bclk[0]) |-> (run[0] == lo_len[0]));

   p_duty_b_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
      (lo_ok[1] && tog[1] && !bclk[1]) |-> (run[1] == lo_len[1]));

endmodule

bind clkbank_ctrl clkbank_chk #(
   .CNT_W      (CNT_W),
   .DIV_C0     (DIV_C0),
   .DIV_C1     (DIV_C1),
   .DIV_C2     (DIV_C2),
   .DIV_C3     (DIV_C3),
   .TEST_DIV_A (TEST_DIV_A),
   .TEST_DIV_B (TEST_DIV_B)
) u_chk (
   .clk_in     (clk_in),
   .rst_n      (rst_n),
   .ctl_we     (ctl_we),
   .ctl_wdata  (ctl_wdata),
   .ctl_q      (ctl_q),
   .req_half_a (req_half[0]),
   .req_half_b (req_half[1]),
   .clk_a      (clk_a),
   .clk_b      (clk_b)
);

// File: tb/clkbank_ctrl_test.sv
module clkbank_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int LIMIT      = 150000;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] sa_pin, sb_pin;
   logic [7:0] ctl_wdata;
   logic       ctl_we;
   logic       clk_a, clk_b, ref_clk;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   clkbank_ctrl uut (
      .clk_in    (clk),
      .rst_n     (rst_n),
      .sa_pin    (sa_pin),
      .sb_pin    (sb_pin),
      .ctl_wdata (ctl_wdata),
      .ctl_we    (ctl_we),
      .clk_a     (clk_a),
      .clk_b     (clk_b),
      .ref_clk   (ref_clk)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // half period of each code, from R6
   function automatic int half_of(int code);
      case (code)
         0:       return 2;
         1:       return 3;
         2:       return 4;
         default: return 6;
      endcase
   endfunction

   function automatic logic get(int b);
      return (b == 0) ? clk_a : clk_b;
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > LIMIT) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
         finish_up();
      end
   end

   task automatic write_ctl(logic [7:0] v);
      @(negedge clk);
      ctl_wdata = v;
      ctl_we    = 1'b1;
      @(negedge clk);
      ctl_we    = 1'b0;
   endtask

   // one full period sampled at falling edges of the input clock
   task automatic measure(int b, output int hi, output int lo);
      int guard = 0;
      hi = 0;
      lo = 0;
      @(negedge clk);
      while (get(b) !== 1'b0 && guard < 200) begin @(negedge clk); guard++; end
      while (get(b) !== 1'b1 && guard < 200) begin @(negedge clk); guard++; end
      while (get(b) === 1'b1 && guard < 200) begin hi++; @(negedge clk); guard++; end
      while (get(b) === 1'b0 && guard < 200) begin lo++; @(negedge clk); guard++; end
   endtask

   task automatic expect_half(string req, int b, int half);
      int hi, lo;
      measure(b, hi, lo);
      measure(b, hi, lo);
      check(req, hi, half);
      check(req, lo, half);
   endtask

   task automatic t_reset();
      rst_n     = 1'b0;
      ctl_we    = 1'b0;
      ctl_wdata = 8'h00;
      sa_pin    = 2'd1;
      sb_pin    = 2'd2;
      repeat (5) @(negedge clk);
      check("R4 clk_a low in reset", int'(clk_a), 0);
      check("R4 clk_b low in reset", int'(clk_b), 0);
      rst_n = 1'b1;
      // reset byte selects normal mode and pin source
      expect_half("R4 R5 bank A after reset", 0, 3);
      expect_half("R4 R5 bank B after reset", 1, 4);
   endtask

   task automatic t_pin_codes();
      for (int c = 0; c < 4; c++) begin
         sa_pin = 2'(c);
         sb_pin = 2'(3 - c);
         expect_half("R5 R6 pin code bank A", 0, half_of(c));
         expect_half("R5 R6 pin code bank B", 1, half_of(3 - c));
      end
   endtask

   task automatic t_reg_mode();
      sa_pin = 2'd0;
      sb_pin = 2'd0;
      // bit7=1, bits4:3 = B code, bits2:1 = A code, bit0=0
      write_ctl({1'b1, 2'b00, 2'd1, 2'd3, 1'b0});
      expect_half("R7 reg code bank A", 0, 6);
      expect_half("R7 reg code bank B", 1, 3);
      sa_pin = 2'd1;
      sb_pin = 2'd2;
      expect_half("R8 pins ignored bank A", 0, 6);
      expect_half("R8 pins ignored bank B", 1, 3);
      write_ctl({1'b1, 2'b00, 2'd0, 2'd2, 1'b0});
      expect_half("R7 reg code bank A second", 0, 4);
      expect_half("R7 reg code bank B second", 1, 2);
   endtask

   task automatic t_we_ignored();
      @(negedge clk);
      ctl_wdata = 8'h00;
      ctl_we    = 1'b0;
      expect_half("R11 no strobe bank A", 0, 4);
      expect_half("R11 no strobe bank B", 1, 2);
   endtask

   task automatic t_ref();
      for (int i = 0; i < 3; i++) begin
         @(posedge clk);
         #1;
         check("R3 ref high", int'(ref_clk), 1);
         @(negedge clk);
         #1;
         check("R3 ref low", int'(ref_clk), 0);
      end
   endtask

   task automatic t_test_mode();
      sa_pin = 2'd3;
      sb_pin = 2'd3;
      write_ctl(8'h01);
      expect_half("R1 R10 test over pins bank A", 0, 3);
      expect_half("R2 R10 test over pins bank B", 1, 2);
      t_ref();
      write_ctl(8'h1E);
      expect_half("R1 R10 test over reg bank A", 0, 3);
      expect_half("R2 R10 test over reg bank B", 1, 2);
      write_ctl(8'h81);
      t_ref();
   endtask

   task automatic record4(int b, output int r0, output int r1, output int r2, output int r3);
      int   runs [4];
      int   guard = 0;
      logic v;
      v = get(b);
      while (get(b) === v && guard < 200) begin @(negedge clk); guard++; end
      for (int i = 0; i < 4; i++) begin
         runs[i] = 0;
         v = get(b);
         while (get(b) === v && guard < 200) begin runs[i]++; @(negedge clk); guard++; end
      end
      r0 = runs[0]; r1 = runs[1]; r2 = runs[2]; r3 = runs[3];
   endtask

   task automatic t_change();
      int r0, r1, r2, r3;
      int guard = 0;
      // bank A: ratio 12 to 4 during a low phase
      sa_pin = 2'd3;
      expect_half("R9 bank A start ratio", 0, 6);
      @(negedge clk);
      while (clk_a !== 1'b1 && guard < 200) begin @(negedge clk); guard++; end
      while (clk_a !== 1'b0 && guard < 200) begin @(negedge clk); guard++; end
      @(negedge clk);
      @(negedge clk);
      sa_pin = 2'd0;
      record4(0, r0, r1, r2, r3);
      check("R9 A high finishes old period", r0, 6);
      check("R9 A low new ratio", r1, 2);
      check("R9 A high new ratio", r2, 2);
      check("R9 A low new ratio again", r3, 2);
      // bank B: ratio 4 to 12 during a high phase
      sb_pin = 2'd0;
      expect_half("R9 bank B start ratio", 1, 2);
      guard = 0;
      @(negedge clk);
      while (clk_b !== 1'b0 && guard < 200) begin @(negedge clk); guard++; end
      while (clk_b !== 1'b1 && guard < 200) begin @(negedge clk); guard++; end
      sb_pin = 2'd3;
      record4(1, r0, r1, r2, r3);
      check("R9 B low new ratio", r0, 6);
      check("R9 B high new ratio", r1, 6);
      check("R9 B low steady", r2, 6);
      check("R9 B high steady", r3, 6);
   endtask

   initial begin
      t_reset();
      t_pin_codes();
      t_reg_mode();
      t_we_ignored();
      t_test_mode();
      t_change();
      finish_up();
   end

endmodule